// File: doc/BRIEF.md
# Debug breakpoint and halt controller

This block decides when a processor core stops for debug. Three sources can stop it: a manual breakpoint request pin, a bank of programmable program-counter comparators, and an external trigger. The core reports its current PC and pulses a strobe each time an instruction retires. Every stop takes effect on one of those strobes, so the core always halts between instructions and never in the middle of one.

The comparators form the first trigger level and the external trigger input forms the second. A mode bit chooses whether a halt needs both levels or either one. Another control bit turns the manual breakpoint into a one-cycle debug interrupt request, so the core is not halted. While the core is halted the 4-bit status output is forced to 0xF. At all other times it passes through the status value the core supplies. A go pulse resumes the core.

Register writes arrive on a valid/ready port. The ready signal is always high, so the port never applies back-pressure and every cycle with valid high commits one write. These writes are how debug commands program the block. A write changes only the register it addresses, and it never clears a latched request or a recorded trigger.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A breakpoint request is latched on the clock edge where `brk_req_i` is high. It halts the core only at a later edge where `insn_done_i` is high. `halted_o` rises on that edge and never before it.
- R2: While `halted_o` is 1, `pst_o` is 4'hF. Otherwise `pst_o` equals `core_pst_i`.
- R3: When control bit 0 (breakpoint-to-interrupt) is 1, a serviced breakpoint request drives `dbg_irq_o` high for exactly one cycle after the retiring edge, and `halted_o` stays 0.
- R4: A one-cycle `brk_req_i` pulse stays pending over any number of cycles with no retiring instruction, and it is serviced at the next retiring edge.
- R5: Comparator i sits at write address i+1 and its enable is control bit 8+i. When it is enabled and `pc_i` equals its value at a clock edge, level 1 is recorded. A later retiring edge then halts the core, provided the combine rule is met.
- R6: A comparator whose enable bit is 0 never records a match, even when `pc_i` equals its value.
- R7: When control bit 1 is 0, a halt needs both level 1 and a recorded `trig2_i` (AND). When control bit 1 is 1, either level alone is enough (OR). A recorded level persists until a halt is taken.
- R8: While halted, `insn_done_i` has no effect. A `go_i` high at an edge clears `halted_o` after that edge. A breakpoint requested during the halt is serviced at the first retiring edge after resuming.
- R9: Register writes never clear a pending breakpoint request or a recorded trigger level.
- R10: `rev_o` always reads 4'h9, and `wr_ready_o` is always 1.
- R11: After reset, `halted_o` and `dbg_irq_o` are 0, every comparator is disabled and cleared, and the combine rule is AND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_req_i | input | 1 | Manual breakpoint request |
| trig2_i | input | 1 | Level-2 external trigger |
| go_i | input | 1 | Resume from halt |
| insn_done_i | input | 1 | Instruction-retire strobe |
| pc_i | input | 32 | Current program counter |
| core_pst_i | input | 4 | Status value supplied by the core |
| wr_valid_i | input | 1 | Register write valid |
| wr_ready_o | output | 1 | Register write ready (always 1) |
| wr_addr_i | input | 3 | 0 = control, i+1 = comparator i |
| wr_data_i | input | 32 | Register write data |
| halted_o | output | 1 | Core is halted |
| dbg_irq_o | output | 1 | One-cycle debug interrupt request |
| pst_o | output | 4 | Processor status output |
| rev_o | output | 4 | Debug revision code |

## Verification
The main path is tried with three breakpoint patterns. In the first, the request and the retire strobe come a cycle apart. In the second, the request pulse comes long before the retire strobe. In the third, the request arrives while the core is halted. Together these separate correct latching from sampling the request only on the retire edge. The comparator path is run with a matching PC on an enabled slot and on a disabled slot, which separates enable gating from plain address compare. The trigger combiner is driven with only level 1, then adding level 2, in AND mode, and with level 2 alone in OR mode. This shows that the mode bit really selects the rule. Writes issued between a request and its service show whether command traffic disturbs the pending state.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned BKD_BIT   = 0;
  localparam int unsigned OR_BIT    = 1;
  localparam int unsigned EN_LSB    = 8;
  localparam logic [3:0]  PST_HALT  = 4'hF;
  localparam logic [3:0]  REV_CODE  = 4'h9;

  typedef struct packed {
    logic bkd;
    logic or_mode;
  } dbg_mode_t;
endpackage

// File: rtl/dbg_pc_cmp.sv
module dbg_pc_cmp #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PC_W-1:0] load_val_i,
  input  logic            en_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            hit_o
);
  logic [PC_W-1:0] bp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bp_q <= '0;
    else if (load_i) bp_q <= load_val_i;
  end

  assign hit_o = en_i && (pc_i == bp_q);
endmodule

// File: rtl/dbg_trig_combine.sv
module dbg_trig_combine #(
  parameter int unsigned N_CMP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CMP-1:0] hits_i,
  input  logic             trig2_i,
  input  logic             or_mode_i,
  input  logic             clr_i,
  output logic             fire_o
);
  logic lvl1_q, lvl2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl1_q <= 1'b0;
      lvl2_q <= 1'b0;
    end else if (clr_i) begin
      lvl1_q <= 1'b0;
      lvl2_q <= 1'b0;
    end else begin
      lvl1_q <= lvl1_q | (|hits_i);
      lvl2_q <= lvl2_q | trig2_i;
    end
  end

  assign fire_o = or_mode_i ? (lvl1_q | lvl2_q) : (lvl1_q & lvl2_q);
endmodule

// File: rtl/dbg_halt_seq.sv
module dbg_halt_seq
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       brk_req_i,
  input  logic       insn_done_i,
  input  logic       go_i,
  input  logic       bkd_i,
  input  logic       trig_fire_i,
  input  logic [3:0] core_pst_i,
  output logic       take_halt_o,
  output logic       halted_o,
  output logic       irq_o,
  output logic [3:0] pst_o
);
  logic halted_q, irq_q, pend_q;
  logic serve;

  assign serve       = insn_done_i && !halted_q;
  assign take_halt_o = serve && ((pend_q && !bkd_i) || trig_fire_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      irq_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      irq_q  <= serve && pend_q && bkd_i;
      pend_q <= brk_req_i || (pend_q && !serve);
      if (halted_q) halted_q <= !go_i;
      else          halted_q <= take_halt_o;
    end
  end

  assign halted_o = halted_q;
  assign irq_o    = irq_q;
  assign pst_o    = halted_q ? PST_HALT : core_pst_i;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int unsigned N_CMP  = 4,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_req_i,
  input  logic              trig2_i,
  input  logic              go_i,
  input  logic              insn_done_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [3:0]        core_pst_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              halted_o,
  output logic              dbg_irq_o,
  output logic [3:0]        pst_o,
  output logic [3:0]        rev_o
);
  localparam int unsigned LOAD_W = (PC_W < 32) ? PC_W : 32;

  dbg_mode_t        mode_q;
  logic [N_CMP-1:0] en_q;
  logic [N_CMP-1:0] hits;
  logic             fire, take_halt, ctrl_wr;

  assign wr_ready_o = 1'b1;
  assign rev_o      = REV_CODE;
  assign ctrl_wr    = wr_valid_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
    end else if (ctrl_wr) begin
      mode_q.bkd     <= wr_data_i[BKD_BIT];
      mode_q.or_mode <= wr_data_i[OR_BIT];
      en_q           <= wr_data_i[EN_LSB +: N_CMP];
    end
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    logic            load;
    logic [PC_W-1:0] val;
    assign load = wr_valid_i && (wr_addr_i == ADDR_W'(g + 1));
    assign val  = PC_W'(wr_data_i[LOAD_W-1:0]);
    dbg_pc_cmp #(.PC_W(PC_W)) i_cmp (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(val),
      .en_i(en_q[g]), .pc_i(pc_i), .hit_o(hits[g])
    );
  end

  dbg_trig_combine #(.N_CMP(N_CMP)) i_comb (
    .clk(clk), .rst_n(rst_n), .hits_i(hits), .trig2_i(trig2_i),
    .or_mode_i(mode_q.or_mode), .clr_i(take_halt), .fire_o(fire)
  );

  dbg_halt_seq i_seq (
    .clk(clk), .rst_n(rst_n), .brk_req_i(brk_req_i),
    .insn_done_i(insn_done_i), .go_i(go_i), .bkd_i(mode_q.bkd),
    .trig_fire_i(fire), .core_pst_i(core_pst_i), .take_halt_o(take_halt),
    .halted_o(halted_o), .irq_o(dbg_irq_o), .pst_o(pst_o)
  );
endmodule

// File: rtl/dbg_halt_chk.sv
module dbg_halt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_done_i,
  input logic       go_i,
  input logic [3:0] core_pst_i,
  input logic       halted_o,
  input logic       dbg_irq_o,
  input logic [3:0] pst_o
);
  AST_PST_HALTED: assert property (@(posedge clk) disable iff (!rst_n) halted_o |-> pst_o == 4'hF); // R2
  AST_PST_RUNNING: assert property (@(posedge clk) disable iff (!rst_n) !halted_o |-> pst_o == core_pst_i); // R2
  AST_HALT_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) $rose(halted_o) |-> $past(insn_done_i)); // R1
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) dbg_irq_o |=> !dbg_irq_o); // R3
  AST_IRQ_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) $rose(dbg_irq_o) |-> $past(insn_done_i && !halted_o)); // R3
  AST_GO_RESUMES: assert property (@(posedge clk) disable iff (!rst_n) (halted_o && go_i) |=> !halted_o); // R8
  AST_HOLD_HALT: assert property (@(posedge clk) disable iff (!rst_n) (halted_o && !go_i) |=> halted_o); // R8
endmodule

bind dbg_halt_ctrl dbg_halt_chk i_chk (
  .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done_i), .go_i(go_i),
  .core_pst_i(core_pst_i), .halted_o(halted_o), .dbg_irq_o(dbg_irq_o), .pst_o(pst_o)
);

// File: tb/test_dbg_halt_ctrl.sv
module test_dbg_halt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        brk_req_i = 0, trig2_i = 0, go_i = 0, insn_done_i = 0;
  logic [31:0] pc_i = 0;
  logic [3:0]  core_pst_i = 4'h3;
  logic        wr_valid_i = 0;
  logic        wr_ready_o;
  logic [2:0]  wr_addr_i = 0;
  logic [31:0] wr_data_i = 0;
  logic        halted_o, dbg_irq_o;
  logic [3:0]  pst_o, rev_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dbg_halt_ctrl i_dbg_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .brk_req_i(brk_req_i), .trig2_i(trig2_i),
    .go_i(go_i), .insn_done_i(insn_done_i), .pc_i(pc_i), .core_pst_i(core_pst_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .halted_o(halted_o), .dbg_irq_o(dbg_irq_o),
    .pst_o(pst_o), .rev_o(rev_o)
  );

  // behavioural reference
  int          m_halt, m_irq, m_pend, m_l1, m_l2, m_bkd, m_or;
  int          m_en[4];
  logic [31:0] m_bp[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_halt = 0; m_irq = 0; m_pend = 0; m_l1 = 0; m_l2 = 0; m_bkd = 0; m_or = 0;
      for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_bp[i] = 0; end
    end else begin
      int hit, fire, serve, take;
      hit = 0;
      for (int i = 0; i < 4; i++) if (m_en[i] != 0 && pc_i == m_bp[i]) hit = 1;
      fire  = m_or != 0 ? (m_l1 | m_l2) : (m_l1 & m_l2);
      serve = (insn_done_i && m_halt == 0) ? 1 : 0;
      take  = (serve != 0 && ((m_pend != 0 && m_bkd == 0) || fire != 0)) ? 1 : 0;
      m_irq = (serve != 0 && m_pend != 0 && m_bkd != 0) ? 1 : 0;
      m_pend = (brk_req_i || (m_pend != 0 && serve == 0)) ? 1 : 0;
      if (m_halt != 0) m_halt = go_i ? 0 : 1;
      else             m_halt = take;
      if (take != 0) begin m_l1 = 0; m_l2 = 0; end
      else begin m_l1 = m_l1 | hit; m_l2 = m_l2 | int'(trig2_i); end
      if (wr_valid_i) begin
        if (wr_addr_i == 0) begin
          m_bkd = int'(wr_data_i[0]); m_or = int'(wr_data_i[1]);
          for (int i = 0; i < 4; i++) m_en[i] = int'(wr_data_i[8+i]);
        end else if (wr_addr_i <= 4) m_bp[wr_addr_i-1] = wr_data_i;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare against the model away from the active edge
  always @(negedge clk) if (rst_n && !finished) begin
    chk("MODEL halted", 32'(halted_o), 32'(m_halt));
    chk("MODEL irq", 32'(dbg_irq_o), 32'(m_irq));
    chk("MODEL pst", 32'(pst_o), m_halt != 0 ? 32'hF : 32'(core_pst_i));
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      brk_req_i = 0; trig2_i = 0; go_i = 0; insn_done_i = 0; wr_valid_i = 0;
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_valid_i = 1; wr_addr_i = a; wr_data_i = d; cyc();
  endtask

  task automatic retire(); insn_done_i = 1; cyc(); endtask
  task automatic resume(); go_i = 1; cyc(); endtask

  initial begin
    #100000;
    chk("WATCHDOG", 32'd1, 32'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R11 halted after reset", 32'(halted_o), 0);
    chk("R11 irq after reset", 32'(dbg_irq_o), 0);
    chk("R2 pst passes core", 32'(pst_o), 32'h3);
    chk("R10 rev", 32'(rev_o), 32'h9);
    chk("R10 ready", 32'(wr_ready_o), 1);

    // R1 request then retire
    brk_req_i = 1; cyc();
    chk("R1 no halt before retire", 32'(halted_o), 0);
    retire();
    chk("R1 halt at retire", 32'(halted_o), 1);
    chk("R2 pst halted", 32'(pst_o), 32'hF);

    // R8 retire ignored, request during halt kept
    retire();
    chk("R8 still halted", 32'(halted_o), 1);
    brk_req_i = 1; cyc();
    resume();
    chk("R8 go resumes", 32'(halted_o), 0);
    core_pst_i = 4'h5; #1;
    chk("R2 pst after go", 32'(pst_o), 32'h5);
    retire();
    chk("R8 request from halt served", 32'(halted_o), 1);
    resume();

    // R4 short pulse, long wait
    brk_req_i = 1; cyc(); cyc(6);
    chk("R4 pending no halt yet", 32'(halted_o), 0);
    retire();
    chk("R4 pulse served", 32'(halted_o), 1);
    resume();

    // R3 breakpoint to interrupt
    wr(0, 32'h1);
    brk_req_i = 1; cyc();
    retire();
    chk("R3 irq raised", 32'(dbg_irq_o), 1);
    chk("R3 no halt", 32'(halted_o), 0);
    cyc();
    chk("R3 irq one cycle", 32'(dbg_irq_o), 0);

    // R6 disabled comparator
    wr(1, 32'h1000);
    wr(0, 32'h2);
    pc_i = 32'h1000; cyc(); pc_i = 32'h40;
    retire();
    chk("R6 disabled no halt", 32'(halted_o), 0);

    // R5 enabled comparator 0 and 3 (OR mode)
    wr(0, 32'h102);
    pc_i = 32'h1000; cyc(); pc_i = 32'h44;
    retire();
    chk("R5 slot0 halt", 32'(halted_o), 1);
    resume();
    wr(4, 32'h3000);
    wr(0, 32'h802);
    pc_i = 32'h3000; cyc(); pc_i = 32'h48;
    retire();
    chk("R5 slot3 halt", 32'(halted_o), 1);
    resume();

    // R7 AND mode
    wr(2, 32'h2000);
    wr(0, 32'h200);
    pc_i = 32'h2000; cyc(); pc_i = 32'h4C;
    retire();
    chk("R7 AND level1 only", 32'(halted_o), 0);
    trig2_i = 1; cyc();
    retire();
    chk("R7 AND both levels", 32'(halted_o), 1);
    resume();
    wr(0, 32'h2);
    trig2_i = 1; cyc();
    retire();
    chk("R7 OR level2 only", 32'(halted_o), 1);
    resume();

    // R9 writes do not clear pending state
    wr(0, 32'h0);
    brk_req_i = 1; cyc();
    wr(0, 32'h300);
    wr(3, 32'hABCD);
    wr(0, 32'h0);
    retire();
    chk("R9 pending survives writes", 32'(halted_o), 1);
    resume();
    cyc(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule